// File: doc/BRIEF.md
# PWM Time-Base Counter with Two-Stage Prescaler

This block is the timing heart of a two-channel pulse-width modulator. A 16-bit counter advances once per prescaled tick. It can count up, count down, count up and then down, or hold still. The tick rate comes from two 3-bit divider fields: a high-speed multiplier field and a power-of-two field. Both channels share one period value. That value can change at once, or it can wait in a shadow copy until the counter next reaches zero, so a period change never cuts a PWM cycle short.

On every tick that moves the counter, the block raises one-cycle event flags. The flags mark that the counter has reached zero, has reached the period, or matches compare A (channel 0) or compare B (channel 1). A direction bit comes with the flags and lets a later waveform stage tell a rising match from a falling one. Software uses a small word-addressed register port to program the control word, the period and the two compares. Writes take effect in one cycle. Reads are combinational. Register access is a control path, so it uses plain strobes and has no back-pressure.

Top module: `pwm_timebase`

## Requirements
- R1: Registers sit at word offsets 0x00 (control), 0x0A (period), 0x12 (compare A) and 0x14 (compare B). Control reads back masked to bits 12:7, 3 and 1:0 (mask 0x1F8B). Period reads back the last value written. Any other offset reads 0, and writes to it change nothing.
- R2: After reset the count is 0, the direction bit is 1 (up), all event flags are 0 and every register reads 0.
- R3: Control bits 1:0 select the mode. In mode 00 the count steps up and goes from a value at or above the period to 0. In mode 01 the count steps down and goes from 0 to the period.
- R4: In mode 10 the count rises until it reaches the period, then falls until it reaches 0, then rises again. The direction output is 1 while rising and 0 while falling; it is 1 in mode 00 and 0 in mode 01.
- R5: One cycle after a tick that moves the counter, the zero flag is high exactly when the new count is 0. The period flag is high exactly when the new count equals the active period. Both are low in every other cycle.
- R6: One cycle after such a tick, event bit 0 flags a new count equal to compare A and event bit 1 flags a new count equal to compare B.
- R7: The tick ratio is 2^C times M, where C is control bits 12:10 and M is 1 when control bits 9:7 (H) are 0, else 2·H.
- R8: A control write that changes bits 12:7 restarts the prescaler. The next tick comes R clock edges after the write edge, where R is the new ratio.
- R9: When control bit 3 is 0, a period write goes only to the shadow copy. The active period takes the shadow value on the tick that brings the count to 0.
- R10: When control bit 3 is 1, a period write updates the active period at once.
- R11: In mode 11 the count and direction hold and no event flag is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Word offset of the write |
| wr_data | input | 16 | Write data |
| rd_addr | input | 5 | Word offset of the read |
| rd_data | output | 16 | Combinational read data |
| tb_count | output | 16 | Current counter value |
| tb_dir | output | 1 | Count direction, 1 = up |
| evt_zero | output | 1 | New count is zero |
| evt_period | output | 1 | New count equals the active period |
| evt_cmp | output | 2 | Bit 0: compare A match, bit 1: compare B match |

## Verification
A wrong prescaler phase shows up in `tb_count` at the very next tick, because the count moves one tick early or late. A stale active period does not show until the next wrap. The count then goes past the expected turn point, and the period flag fires at the wrong value within one PWM cycle. A wrong direction register shows on `tb_dir` in the cycle after a turnaround, and the count then steps the wrong way. Comparing all outputs against the reference model on every clock therefore catches a bad state no later than one period after it appears.

// File: rtl/pwmtb_pkg.sv
package pwmtb_pkg;
  localparam int ADDR_W = 5;
  localparam int DIV_W  = 3;
  localparam int NCMP   = 2;

  typedef enum logic [1:0] {
    CM_UP   = 2'b00,
    CM_DOWN = 2'b01,
    CM_UPDN = 2'b10,
    CM_HOLD = 2'b11
  } cnt_mode_e;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_PRD  = 5'h0A;
  localparam logic [ADDR_W-1:0] OFS_CMPA = 5'h12;
  localparam logic [ADDR_W-1:0] OFS_CMPB = 5'h14;

  localparam int LOADSEL_BIT = 3;
  localparam int HS_LSB      = 7;
  localparam int CK_LSB      = HS_LSB + DIV_W;
  localparam int DIVF_W      = 2 * DIV_W;
  localparam logic [15:0] CTRL_MASK = 16'h1F8B;
endpackage

// File: rtl/pwmtb_regs.sv
module pwmtb_regs
  import pwmtb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [DATA_W-1:0]              wr_data,
  input  logic [ADDR_W-1:0]              rd_addr,
  input  logic                           zero_load,
  output logic [DATA_W-1:0]              rd_data,
  output logic [DATA_W-1:0]              ctrl_q,
  output logic [DATA_W-1:0]              prd_act,
  output logic [NCMP-1:0][DATA_W-1:0]    cmp_q,
  output logic                           div_change
);
  logic [DATA_W-1:0] prd_shd;
  logic              wr_ctrl, wr_prd;
  logic [DATA_W-1:0] mask_w;

  assign mask_w     = DATA_W'(CTRL_MASK);
  assign wr_ctrl    = wr_en && (wr_addr == OFS_CTRL);
  assign wr_prd     = wr_en && (wr_addr == OFS_PRD);
  assign div_change = wr_ctrl &&
                      (wr_data[HS_LSB +: DIVF_W] != ctrl_q[HS_LSB +: DIVF_W]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      prd_shd <= '0;
      prd_act <= '0;
      cmp_q   <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= wr_data & mask_w;
      if (wr_prd) prd_shd <= wr_data;
      if (wr_prd && ctrl_q[LOADSEL_BIT]) prd_act <= wr_data;
      else if (zero_load)                prd_act <= prd_shd;
      if (wr_en && wr_addr == OFS_CMPA) cmp_q[0] <= wr_data;
      if (wr_en && wr_addr == OFS_CMPB) cmp_q[1] <= wr_data;
    end
  end

  always_comb begin
    case (rd_addr)
      OFS_CTRL: rd_data = ctrl_q;
      OFS_PRD:  rd_data = prd_shd;
      OFS_CMPA: rd_data = cmp_q[0];
      OFS_CMPB: rd_data = cmp_q[1];
      default:  rd_data = '0;
    endcase
  end
endmodule

// File: rtl/pwmtb_prescale.sv
module pwmtb_prescale #(
  parameter int DIV_W = 3,
  parameter int PS_W  = DIV_W + (1 << DIV_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] hs_div,
  input  logic [DIV_W-1:0] ck_div,
  input  logic             restart,
  output logic             tick
);
  logic [PS_W-1:0] pcnt, hs_mul, ratio_m1;

  always_comb begin
    hs_mul   = (hs_div == '0) ? PS_W'(1) : PS_W'({hs_div, 1'b0});
    ratio_m1 = (hs_mul << ck_div) - PS_W'(1);
  end

  assign tick = (pcnt == ratio_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                pcnt <= '0;
    else if (restart || tick)  pcnt <= '0;
    else                       pcnt <= pcnt + PS_W'(1);
  end
endmodule

// File: rtl/pwmtb_counter.sv
module pwmtb_counter
  import pwmtb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  cnt_mode_e         mode,
  input  logic [DATA_W-1:0] prd,
  output logic [DATA_W-1:0] cnt_q,
  output logic              dir_q,
  output logic              step,
  output logic [DATA_W-1:0] cnt_nxt,
  output logic              dir_nxt
);
  localparam logic [DATA_W-1:0] ONE = DATA_W'(1);

  assign step = tick && (mode != CM_HOLD);

  always_comb begin
    cnt_nxt = cnt_q;
    dir_nxt = dir_q;
    case (mode)
      CM_UP: begin
        dir_nxt = 1'b1;
        cnt_nxt = (cnt_q >= prd) ? '0 : cnt_q + ONE;
      end
      CM_DOWN: begin
        dir_nxt = 1'b0;
        cnt_nxt = (cnt_q == '0) ? prd : cnt_q - ONE;
      end
      CM_UPDN: begin
        if (dir_q) begin
          if (cnt_q >= prd) begin
            dir_nxt = 1'b0;
            cnt_nxt = (cnt_q == '0) ? '0 : cnt_q - ONE;
          end else begin
            cnt_nxt = cnt_q + ONE;
          end
        end else begin
          if (cnt_q == '0) begin
            dir_nxt = 1'b1;
            cnt_nxt = (prd == '0) ? '0 : ONE;
          end else begin
            cnt_nxt = cnt_q - ONE;
          end
        end
      end
      default: begin
        cnt_nxt = cnt_q;
        dir_nxt = dir_q;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else if (step) begin
      cnt_q <= cnt_nxt;
      dir_q <= dir_nxt;
    end
  end
endmodule

// File: rtl/pwmtb_match.sv
module pwmtb_match #(
  parameter int DATA_W = 16,
  parameter int NCMP   = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        step,
  input  logic [DATA_W-1:0]           cnt_nxt,
  input  logic [DATA_W-1:0]           prd,
  input  logic [NCMP-1:0][DATA_W-1:0] cmp,
  output logic                        evt_zero,
  output logic                        evt_period,
  output logic [NCMP-1:0]             evt_cmp
);
  logic [NCMP-1:0] hit;

  for (genvar g = 0; g < NCMP; g++) begin : g_cmp
    assign hit[g] = (cnt_nxt == cmp[g]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_zero   <= 1'b0;
      evt_period <= 1'b0;
      evt_cmp    <= '0;
    end else begin
      evt_zero   <= step && (cnt_nxt == '0);
      evt_period <= step && (cnt_nxt == prd);
      evt_cmp    <= step ? hit : '0;
    end
  end
endmodule

// File: rtl/pwm_timebase.sv
module pwm_timebase
  import pwmtb_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [4:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [4:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic [DATA_W-1:0] tb_count,
  output logic              tb_dir,
  output logic              evt_zero,
  output logic              evt_period,
  output logic [1:0]        evt_cmp
);
  localparam int PS_W = DIV_W + (1 << DIV_W);

  logic [DATA_W-1:0]           ctrl_q, prd_act, cnt_nxt;
  logic [NCMP-1:0][DATA_W-1:0] cmp_vec;
  logic                        div_change, ps_tick, step, dir_nxt, zero_load;
  cnt_mode_e                   cur_mode;

  assign cur_mode  = cnt_mode_e'(ctrl_q[1:0]);
  assign zero_load = step && (cnt_nxt == '0);

  pwmtb_regs #(.DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .zero_load(zero_load),
    .rd_data(rd_data), .ctrl_q(ctrl_q), .prd_act(prd_act),
    .cmp_q(cmp_vec), .div_change(div_change)
  );

  pwmtb_prescale #(.DIV_W(DIV_W), .PS_W(PS_W)) u_ps (
    .clk(clk), .rst_n(rst_n),
    .hs_div(ctrl_q[HS_LSB +: DIV_W]), .ck_div(ctrl_q[CK_LSB +: DIV_W]),
    .restart(div_change), .tick(ps_tick)
  );

  pwmtb_counter #(.DATA_W(DATA_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(ps_tick), .mode(cur_mode),
    .prd(prd_act), .cnt_q(tb_count), .dir_q(tb_dir), .step(step),
    .cnt_nxt(cnt_nxt), .dir_nxt(dir_nxt)
  );

  pwmtb_match #(.DATA_W(DATA_W), .NCMP(NCMP)) u_match (
    .clk(clk), .rst_n(rst_n), .step(step), .cnt_nxt(cnt_nxt),
    .prd(prd_act), .cmp(cmp_vec), .evt_zero(evt_zero),
    .evt_period(evt_period), .evt_cmp(evt_cmp)
  );
endmodule

// File: rtl/pwm_timebase_chk.sv
module pwm_timebase_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic [1:0]        mode,
  input logic [DATA_W-1:0] cnt,
  input logic              dir,
  input logic              ez,
  input logic              ep,
  input logic [1:0]        ec,
  input logic [DATA_W-1:0] prd,
  input logic [DATA_W-1:0] cmp_a,
  input logic [DATA_W-1:0] cmp_b
);
  // R3
  up_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'b00 && cnt < prd) |=> (cnt == DATA_W'($past(cnt) + 1'b1)));

  // R3
  down_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'b01 && cnt != '0) |=> (cnt == DATA_W'($past(cnt) - 1'b1)));

  // R4
  up_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mode == 2'b00) |=> dir);

  // R5
  no_tick_no_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> !(ez || ep || ec != 2'b00));

  // R5
  zero_evt_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ez |-> (cnt == '0));

  // R6
  cmpa_evt_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ec[0] |-> (cnt == $past(cmp_a)));

  // R6
  cmpb_evt_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ec[1] |-> (cnt == $past(cmp_b)));

  // R11
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |=> ($stable(cnt) && $stable(dir) && !ez && !ep && ec == 2'b00));
endmodule

bind pwm_timebase pwm_timebase_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(ps_tick), .mode(ctrl_q[1:0]),
  .cnt(tb_count), .dir(tb_dir), .ez(evt_zero), .ep(evt_period),
  .ec(evt_cmp), .prd(prd_act), .cmp_a(cmp_vec[0]), .cmp_b(cmp_vec[1])
);

// File: tb/sim_pwm_timebase.sv
`timescale 1ns/1ps
module sim_pwm_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [15:0] rd_data, tb_count;
  logic        tb_dir, evt_zero, evt_period;
  logic [1:0]  evt_cmp;

  int tests = 0;
  int fails = 0;
  int cyc = 0;
  bit done = 1'b0;
  bit cmp_on = 1'b0;

  always #4 clk = ~clk;

  pwm_timebase u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
    .tb_count(tb_count), .tb_dir(tb_dir), .evt_zero(evt_zero),
    .evt_period(evt_period), .evt_cmp(evt_cmp)
  );

  // reference model state
  int m_cnt, m_dir, m_pc, m_ctrl, m_shd, m_act, m_ca, m_cb;
  int m_ez, m_ep, m_ec;

  function automatic int ratio_of(int ctrl);
    int h = (ctrl >> 7) & 7;
    int c = (ctrl >> 10) & 7;
    return (1 << c) * ((h == 0) ? 1 : 2 * h);
  endfunction

  function automatic int m_read(int a);
    case (a)
      5'h00:   return m_ctrl;
      5'h0A:   return m_shd;
      5'h12:   return m_ca;
      5'h14:   return m_cb;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_dir = 1; m_pc = 0; m_ctrl = 0; m_shd = 0; m_act = 0;
      m_ca = 0; m_cb = 0; m_ez = 0; m_ep = 0; m_ec = 0;
    end else begin
      int mode, nx, nd;
      bit tk;
      mode = m_ctrl & 3;
      tk = (m_pc == ratio_of(m_ctrl) - 1);
      m_ez = 0; m_ep = 0; m_ec = 0;
      if (tk && mode != 3) begin
        nx = m_cnt; nd = m_dir;
        if (mode == 0) begin
          nd = 1; nx = (m_cnt >= m_act) ? 0 : m_cnt + 1;
        end else if (mode == 1) begin
          nd = 0; nx = (m_cnt == 0) ? m_act : m_cnt - 1;
        end else if (m_dir == 1) begin
          if (m_cnt >= m_act) begin nd = 0; nx = (m_cnt == 0) ? 0 : m_cnt - 1; end
          else nx = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin nd = 1; nx = (m_act == 0) ? 0 : 1; end
          else nx = m_cnt - 1;
        end
        m_ez = (nx == 0);
        m_ep = (nx == m_act);
        m_ec = ((nx == m_ca) ? 1 : 0) | ((nx == m_cb) ? 2 : 0);
        if (nx == 0) m_act = m_shd;
        m_cnt = nx; m_dir = nd;
      end
      if (wr_en && wr_addr == 5'h00 && (((wr_data >> 7) & 63) != ((m_ctrl >> 7) & 63)))
        m_pc = 0;
      else if (tk) m_pc = 0;
      else m_pc = m_pc + 1;
      if (wr_en) begin
        case (wr_addr)
          5'h00: m_ctrl = wr_data & 16'h1F8B;
          5'h0A: begin
            m_shd = wr_data;
            if (m_ctrl & 8) m_act = wr_data;
          end
          5'h12: m_ca = wr_data;
          5'h14: m_cb = wr_data;
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  // per-clock comparison against the model, then rotate the read address
  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      chk("R3 count", tb_count, m_cnt);
      chk("R4 direction", tb_dir, m_dir);
      chk("R5 zero event", evt_zero, m_ez);
      chk("R5 period event", evt_period, m_ep);
      chk("R6 compare events", evt_cmp, m_ec);
      chk("R1 readback", rd_data, m_read(rd_addr));
    end
    case (cyc % 6)
      0: rd_addr = 5'h00;
      1: rd_addr = 5'h0A;
      2: rd_addr = 5'h12;
      3: rd_addr = 5'h14;
      4: rd_addr = 5'h04;
      default: rd_addr = 5'h0C;
    endcase
  end

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // write control, then count edges from the write edge to the next count change
  task automatic wr_ctrl_measure(input logic [15:0] d, output int n);
    logic [15:0] c0;
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'h00; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    c0 = tb_count;
    n = 1;
    for (int k = 0; k < 5000; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (tb_count != c0) break;
    end
  endtask

  task automatic steady_measure(output int n);
    logic [15:0] c0;
    c0 = tb_count;
    n = 0;
    for (int k = 0; k < 5000; k++) begin
      @(posedge clk); n++;
      @(negedge clk);
      if (tb_count != c0) break;
    end
  endtask

  task automatic wait_evt(input bit per);
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      if (per ? evt_period : evt_zero) break;
    end
  endtask

  initial begin
    int n;
    logic [15:0] c0;
    repeat (3) @(negedge clk);
    // R2 reset state
    chk("R2 reset count", tb_count, 0);
    chk("R2 reset dir", tb_dir, 1);
    chk("R2 reset events", {evt_zero, evt_period, evt_cmp}, 0);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    idle(6);
    // R1 register programming; R9 shadow load on next zero
    wr(5'h12, 16'd3);
    wr(5'h14, 16'd5);
    wr(5'h0A, 16'd7);
    idle(40);
    // R1 unmapped write and control masking
    wr(5'h04, 16'hFFFF);
    wr(5'h00, 16'hE070);
    idle(12);
    // R3 down mode, R4 up-down mode
    wr(5'h00, 16'h0001);
    idle(40);
    wr(5'h00, 16'h0002);
    idle(60);
    // R8 restart and R7 ratio: C=1, H=2 -> 8
    wr(5'h00, 16'h0000);
    idle(5);
    wr_ctrl_measure(16'h0500, n);
    chk("R8 restart to first tick (ratio 8)", n, 9);
    steady_measure(n);
    chk("R7 steady ratio 8", n, 8);
    idle(30);
    // C=2, H=0 -> 4
    wr_ctrl_measure(16'h0800, n);
    chk("R8 restart to first tick (ratio 4)", n, 5);
    steady_measure(n);
    chk("R7 steady ratio 4", n, 4);
    // up-down at ratio 4 with events
    wr(5'h00, 16'h0802);
    idle(120);
    wr(5'h00, 16'h0000);
    idle(20);
    // R9 shadow: period 7 -> 3 takes effect only after the next zero
    wait_evt(1'b0);
    wr(5'h0A, 16'd3);
    wait_evt(1'b1);
    chk("R9 old period still active", tb_count, 7);
    wait_evt(1'b1);
    chk("R9 shadow period after zero", tb_count, 3);
    // R10 immediate load
    wr(5'h00, 16'h0008);
    wait_evt(1'b0);
    wr(5'h0A, 16'd5);
    wait_evt(1'b1);
    chk("R10 immediate period", tb_count, 5);
    idle(20);
    // R11 freeze
    wr(5'h00, 16'h0003);
    c0 = tb_count;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      chk("R11 frozen count", tb_count, c0);
      chk("R11 no events", {evt_zero, evt_period, evt_cmp}, 0);
    end
    wr(5'h00, 16'h0002);
    idle(30);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule